// File: doc/BRIEF.md
# Half-Bridge Gate Drive Sequencer

This block sits between a voltage-regulator controller's PWM command and the two gate drivers of one synchronous buck phase. Every analog quantity reaches it as a digitised comparator flag: the PWM level, whether PWM sits in the mid-level (tristate) window, whether each gate has discharged below its safe level, whether inductor current has fallen to zero or below, supply undervoltage, and two temperature comparators. From these it decides, on every clock, whether the high-side or low-side switch may be on.

Each transition breaks before it makes. The conducting gate is dropped at once, and the opposite gate is enabled only after its partner is sensed discharged, so the dead time follows the real gate slew. A PWM input parked in the tristate window for a programmable number of cycles turns both switches off. An active-low disable input, an undervoltage flag, and a skip mode that stops low-side conduction at zero current all gate the outputs. A separate hysteretic thermal warning flag is set and cleared by two temperature comparators and has no effect on switching.

Top module: `hb_gate_seq`

## Requirements
- R1: When PWM is high, the low-side enable drops first. The high-side enable rises only in a cycle where the low-side enable is already low and the synchronised low-side-discharged flag was high one cycle earlier. While that flag stays low, both enables stay low.
- R2: When PWM is low, the high-side enable drops first. The low-side enable rises only after the high-side enable is low and the synchronised high-side-discharged flag is high.
- R3: The high-side and low-side enables are never both high in the same cycle, for any input sequence.
- R4: When the synchronised tristate flag stays high for HOLD_CYC consecutive cycles, both enables go low at the edge that closes the HOLD_CYC-th cycle. They stay low until the flag drops. A shorter excursion has no effect, and any low cycle restarts the count.
- R5: While the active-low disable input is low, both enables are low.
- R6: With skip mode active (skip input low) and PWM low, the low-side enable is high only while the zero-current flag is low. High-side operation is unchanged.
- R7: With the skip input high, the stage is fully synchronous. PWM low gives the low-side enable and PWM high gives the high-side enable, whatever the zero-current flag reads.
- R8: While the undervoltage flag is high, both enables are low.
- R9: The thermal warning output sets when the over-temperature comparator is high. It clears when the below-clear comparator is high, with set taking priority. It holds its value when both are low. Its state never changes the gate enables.
- R10: Every comparator and control input passes through a two-flop synchroniser, and the enables are registered. A command change first shows on the enables at the third rising edge after it is applied.
- R11: While reset is asserted, both enables and the thermal warning are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwm_hi_i | input | 1 | PWM above its high threshold (async) |
| pwm_mid_i | input | 1 | PWM inside the tristate window (async) |
| hs_dis_i | input | 1 | High-side gate sensed below its safe level (async) |
| ls_dis_i | input | 1 | Low-side gate sensed below its safe level (async) |
| il_nonpos_i | input | 1 | Inductor current at or below zero (async) |
| run_n_i | input | 1 | Active-low disable, low stops the stage (async) |
| skip_n_i | input | 1 | Active-low skip mode enable (async) |
| uv_i | input | 1 | Supply undervoltage flag (async) |
| hot_set_i | input | 1 | Junction at or above the warning-set temperature (async) |
| hot_clr_i | input | 1 | Junction below the warning-clear temperature (async) |
| hs_en_o | output | 1 | High-side gate enable |
| ls_en_o | output | 1 | Low-side gate enable |
| hot_warn_o | output | 1 | Thermal warning flag |

## Verification
The bench holds the low-side-discharged flag low across a PWM rise. A design with a fixed dead time, or one that ignores the sense flag, would turn the high side on while the low side could still be conducting. It times the tristate hold-off to the exact edge, using one pulse a cycle short of the limit and a pair of short pulses split by one low cycle. A counter that does not restart, or that is off by one, would switch the stage off early or late. Skip mode is checked with the zero-current flag both high and low. A design that applied diode emulation in synchronous mode, or to the high side, would drop a switch it should keep on. The thermal flag is held between its two thresholds to expose a design that loses or sets the warning without cause.

// File: rtl/hb_gate_pkg.sv
package hb_gate_pkg;

    // Positions of the asynchronous inputs inside the synchroniser vector
    localparam int unsigned IX_PWM_HI  = 0;
    localparam int unsigned IX_PWM_MID = 1;
    localparam int unsigned IX_HS_DIS  = 2;
    localparam int unsigned IX_LS_DIS  = 3;
    localparam int unsigned IX_IL_NP   = 4;
    localparam int unsigned IX_RUN_N   = 5;
    localparam int unsigned IX_SKIP_N  = 6;
    localparam int unsigned IX_UV      = 7;
    localparam int unsigned IX_HOT_SET = 8;
    localparam int unsigned IX_HOT_CLR = 9;
    localparam int unsigned N_ASYNC    = 10;

    typedef struct packed {
        logic hs;
        logic ls;
    } gate_pair_t;

endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
    parameter int unsigned WIDTH  = 1,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = async_i;
        for (int s = 1; s < int'(STAGES); s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/hb_tri_holdoff.sv
module hb_tri_holdoff #(
    parameter int unsigned HOLD_CYC = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mid_i,
    output logic park_o
);
    localparam int unsigned CW   = (HOLD_CYC > 2) ? $clog2(HOLD_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(HOLD_CYC - 1);

    typedef struct packed {
        logic [CW-1:0] run;
    } hold_st_t;

    hold_st_t st_d, st_q;

    // run counts earlier consecutive window cycles; the current one makes HOLD_CYC at LAST
    always_comb begin
        st_d = st_q;
        if (!mid_i)              st_d.run = '0;
        else if (st_q.run != LAST) st_d.run = st_q.run + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign park_o = mid_i && (st_q.run == LAST);
endmodule

// File: rtl/hb_therm_flag.sv
module hb_therm_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic hot_set_i,
    input  logic hot_clr_i,
    output logic warn_o
);
    typedef struct packed {
        logic warn;
    } therm_st_t;

    therm_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (hot_set_i)      st_d.warn = 1'b1;
        else if (hot_clr_i) st_d.warn = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign warn_o = st_q.warn;
endmodule

// File: rtl/hb_gate_core.sv
module hb_gate_core
    import hb_gate_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic allow_i,
    input  logic pwm_hi_i,
    input  logic hs_dis_i,
    input  logic ls_dis_i,
    input  logic il_nonpos_i,
    input  logic skip_n_i,
    output logic hs_en_o,
    output logic ls_en_o
);
    gate_pair_t st_d, st_q;
    logic want_hs, want_ls;

    always_comb begin
        want_hs = allow_i && pwm_hi_i;
        want_ls = allow_i && !pwm_hi_i && (skip_n_i || !il_nonpos_i);
        // Turn-off is immediate; turn-on waits for the partner to be off and discharged
        st_d.hs = want_hs && !st_q.ls && ls_dis_i;
        st_d.ls = want_ls && !st_q.hs && hs_dis_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hs_en_o = st_q.hs;
    assign ls_en_o = st_q.ls;
endmodule

// File: rtl/hb_gate_seq.sv
module hb_gate_seq
    import hb_gate_pkg::*;
#(
    parameter int unsigned HOLD_CYC    = 15,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwm_hi_i,
    input  logic pwm_mid_i,
    input  logic hs_dis_i,
    input  logic ls_dis_i,
    input  logic il_nonpos_i,
    input  logic run_n_i,
    input  logic skip_n_i,
    input  logic uv_i,
    input  logic hot_set_i,
    input  logic hot_clr_i,
    output logic hs_en_o,
    output logic ls_en_o,
    output logic hot_warn_o
);
    logic [N_ASYNC-1:0] raw_vec, syn_vec;
    logic pwm_hi_s, pwm_mid_s, hs_dis_s, ls_dis_s, il_np_s;
    logic run_n_s, skip_n_s, uv_s, hot_set_s, hot_clr_s;
    logic parked, allow;

    always_comb begin
        raw_vec             = '0;
        raw_vec[IX_PWM_HI]  = pwm_hi_i;
        raw_vec[IX_PWM_MID] = pwm_mid_i;
        raw_vec[IX_HS_DIS]  = hs_dis_i;
        raw_vec[IX_LS_DIS]  = ls_dis_i;
        raw_vec[IX_IL_NP]   = il_nonpos_i;
        raw_vec[IX_RUN_N]   = run_n_i;
        raw_vec[IX_SKIP_N]  = skip_n_i;
        raw_vec[IX_UV]      = uv_i;
        raw_vec[IX_HOT_SET] = hot_set_i;
        raw_vec[IX_HOT_CLR] = hot_clr_i;
    end

    hb_sync #(.WIDTH(N_ASYNC), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_vec),
        .sync_o  (syn_vec)
    );

    assign pwm_hi_s  = syn_vec[IX_PWM_HI];
    assign pwm_mid_s = syn_vec[IX_PWM_MID];
    assign hs_dis_s  = syn_vec[IX_HS_DIS];
    assign ls_dis_s  = syn_vec[IX_LS_DIS];
    assign il_np_s   = syn_vec[IX_IL_NP];
    assign run_n_s   = syn_vec[IX_RUN_N];
    assign skip_n_s  = syn_vec[IX_SKIP_N];
    assign uv_s      = syn_vec[IX_UV];
    assign hot_set_s = syn_vec[IX_HOT_SET];
    assign hot_clr_s = syn_vec[IX_HOT_CLR];

    hb_tri_holdoff #(.HOLD_CYC(HOLD_CYC)) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .mid_i  (pwm_mid_s),
        .park_o (parked)
    );

    assign allow = run_n_s && !uv_s && !parked;

    hb_gate_core u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .allow_i     (allow),
        .pwm_hi_i    (pwm_hi_s),
        .hs_dis_i    (hs_dis_s),
        .ls_dis_i    (ls_dis_s),
        .il_nonpos_i (il_np_s),
        .skip_n_i    (skip_n_s),
        .hs_en_o     (hs_en_o),
        .ls_en_o     (ls_en_o)
    );

    hb_therm_flag u_therm (
        .clk       (clk),
        .rst_n     (rst_n),
        .hot_set_i (hot_set_s),
        .hot_clr_i (hot_clr_s),
        .warn_o    (hot_warn_o)
    );
endmodule

// File: rtl/hb_gate_seq_chk.sv
module hb_gate_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic hs,
    input logic ls,
    input logic warn,
    input logic ls_dis_s,
    input logic hs_dis_s,
    input logic run_n_s,
    input logic uv_s,
    input logic skip_n_s,
    input logic il_np_s,
    input logic parked,
    input logic hot_set_s,
    input logic hot_clr_s
);
    p_hs_after_ls_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs) |-> ($past(!ls) && $past(ls_dis_s)));

    p_ls_after_hs_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ls) |-> ($past(!hs) && $past(hs_dis_s)));

    p_no_overlap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs && ls));

    p_park_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        parked |=> (!hs && !ls));

    p_disable_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !run_n_s |=> (!hs && !ls));

    p_skip_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!skip_n_s && il_np_s) |=> !ls);

    p_uv_clamp_r8: assert property (@(posedge clk) disable iff (!rst_n)
        uv_s |=> (!hs && !ls));

    p_warn_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        hot_set_s |=> warn);

    p_warn_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!hot_set_s && !hot_clr_s) |=> (warn == $past(warn)));
endmodule

bind hb_gate_seq hb_gate_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .hs        (hs_en_o),
    .ls        (ls_en_o),
    .warn      (hot_warn_o),
    .ls_dis_s  (ls_dis_s),
    .hs_dis_s  (hs_dis_s),
    .run_n_s   (run_n_s),
    .uv_s      (uv_s),
    .skip_n_s  (skip_n_s),
    .il_np_s   (il_np_s),
    .parked    (parked),
    .hot_set_s (hot_set_s),
    .hot_clr_s (hot_clr_s)
);

// File: tb/hb_gate_seq_bench.sv
module hb_gate_seq_bench;
    localparam int unsigned HOLD = 15;
    localparam int NV = 13;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwm_hi = 1'b0, pwm_mid = 1'b0, hs_dis = 1'b1, ls_dis = 1'b1;
    logic il_np = 1'b0, run_n = 1'b1, skip_n = 1'b1, uv = 1'b0;
    logic hot_set = 1'b0, hot_clr = 1'b0;
    logic hs_en, ls_en, hot_warn;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    hb_gate_seq #(.HOLD_CYC(HOLD)) u_hb_gate_seq (
        .clk(clk), .rst_n(rst_n),
        .pwm_hi_i(pwm_hi), .pwm_mid_i(pwm_mid),
        .hs_dis_i(hs_dis), .ls_dis_i(ls_dis),
        .il_nonpos_i(il_np), .run_n_i(run_n), .skip_n_i(skip_n), .uv_i(uv),
        .hot_set_i(hot_set), .hot_clr_i(hot_clr),
        .hs_en_o(hs_en), .ls_en_o(ls_en), .hot_warn_o(hot_warn)
    );

    // {tag, pwm_hi, pwm_mid, run_n, skip_n, il_np, uv, exp_hs, exp_ls}
    localparam logic [11:0] VEC [NV] = '{
        {4'd7, 6'b101100, 2'b10},  // R7 PWM high, sync
        {4'd7, 6'b001100, 2'b01},  // R7 PWM low, sync
        {4'd7, 6'b001110, 2'b01},  // R7 zero current ignored
        {4'd6, 6'b001000, 2'b01},  // R6 skip, current positive
        {4'd6, 6'b001010, 2'b00},  // R6 skip, current zero
        {4'd6, 6'b101010, 2'b10},  // R6 high side untouched
        {4'd5, 6'b100100, 2'b00},  // R5 disabled, PWM high
        {4'd5, 6'b000100, 2'b00},  // R5 disabled, PWM low
        {4'd8, 6'b101101, 2'b00},  // R8 undervoltage, PWM high
        {4'd8, 6'b001101, 2'b00},  // R8 undervoltage, PWM low
        {4'd4, 6'b011100, 2'b00},  // R4 parked from low
        {4'd4, 6'b111100, 2'b00},  // R4 parked from high
        {4'd4, 6'b101100, 2'b10}   // R4 resume after window
    };

    function automatic string tag_of(input logic [3:0] c);
        case (c)
            4'd4:    return "R4";
            4'd5:    return "R5";
            4'd6:    return "R6";
            4'd7:    return "R7";
            4'd8:    return "R8";
            default: return "R?";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [1:0] act, input logic [1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic edges_then_sample(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        // R11 reset state
        repeat (3) @(negedge clk);
        chk("R11 gates in reset", {hs_en, ls_en}, 2'b00);
        chk("R11 warn in reset", {1'b0, hot_warn}, 2'b00);
        rst_n = 1'b1;

        // Vector table
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            {pwm_hi, pwm_mid, run_n, skip_n, il_np, uv} = VEC[i][7:2];
            edges_then_sample(HOLD + 8);
            chk(tag_of(VEC[i][11:8]), {hs_en, ls_en}, VEC[i][1:0]);
        end

        // R10 latency and R1 ordering from steady low side
        {pwm_hi, pwm_mid, run_n, skip_n, il_np, uv} = 6'b001100;
        edges_then_sample(8);
        chk("R10 settled low side", {hs_en, ls_en}, 2'b01);
        pwm_hi = 1'b1;
        edges_then_sample(2);
        chk("R10 no change after two edges", {hs_en, ls_en}, 2'b01);
        edges_then_sample(1);
        chk("R1 low side off first", {hs_en, ls_en}, 2'b00);
        edges_then_sample(1);
        chk("R1 high side on next", {hs_en, ls_en}, 2'b10);

        // R1 adaptive: high side waits for low-side discharge flag
        pwm_hi = 1'b0;
        edges_then_sample(8);
        ls_dis = 1'b0;
        pwm_hi = 1'b1;
        edges_then_sample(10);
        chk("R1 waits for low-side discharge", {hs_en, ls_en}, 2'b00);
        ls_dis = 1'b1;
        edges_then_sample(2);
        chk("R1 still off before sync", {hs_en, ls_en}, 2'b00);
        edges_then_sample(1);
        chk("R1 on after discharge seen", {hs_en, ls_en}, 2'b10);

        // R2 adaptive: low side waits for high-side discharge flag
        hs_dis = 1'b0;
        pwm_hi = 1'b0;
        edges_then_sample(10);
        chk("R2 waits for high-side discharge", {hs_en, ls_en}, 2'b00);
        hs_dis = 1'b1;
        edges_then_sample(2);
        chk("R2 still off before sync", {hs_en, ls_en}, 2'b00);
        edges_then_sample(1);
        chk("R2 on after discharge seen", {hs_en, ls_en}, 2'b01);

        // R4 hold-off timing with high side on
        pwm_hi = 1'b1;
        edges_then_sample(8);
        pwm_mid = 1'b1;
        repeat (HOLD - 1) @(negedge clk);
        pwm_mid = 1'b0;
        edges_then_sample(6);
        chk("R4 short excursion ignored", {hs_en, ls_en}, 2'b10);
        pwm_mid = 1'b1;
        repeat (HOLD - 1) @(negedge clk);
        pwm_mid = 1'b0;
        @(negedge clk);
        pwm_mid = 1'b1;
        repeat (HOLD - 1) @(negedge clk);
        pwm_mid = 1'b0;
        edges_then_sample(6);
        chk("R4 count restarts after gap", {hs_en, ls_en}, 2'b10);
        pwm_mid = 1'b1;
        edges_then_sample(HOLD + 1);
        chk("R4 still on at limit minus one", {hs_en, ls_en}, 2'b10);
        edges_then_sample(1);
        chk("R4 off at hold-off limit", {hs_en, ls_en}, 2'b00);
        pwm_mid = 1'b0;
        edges_then_sample(6);
        chk("R4 resumes on exit", {hs_en, ls_en}, 2'b10);

        // R9 thermal flag with switching continuing
        hot_set = 1'b1;
        edges_then_sample(2);
        chk("R9 warn not yet", {1'b0, hot_warn}, 2'b00);
        edges_then_sample(1);
        chk("R9 warn set", {1'b0, hot_warn}, 2'b01);
        hot_set = 1'b0;
        edges_then_sample(8);
        chk("R9 warn held between thresholds", {1'b0, hot_warn}, 2'b01);
        chk("R9 switching continues", {hs_en, ls_en}, 2'b10);
        pwm_hi = 1'b0;
        edges_then_sample(8);
        chk("R9 low side under warning", {hs_en, ls_en}, 2'b01);
        hot_clr = 1'b1;
        hot_set = 1'b1;
        edges_then_sample(6);
        chk("R9 set wins over clear", {1'b0, hot_warn}, 2'b01);
        hot_set = 1'b0;
        edges_then_sample(6);
        chk("R9 warn cleared", {1'b0, hot_warn}, 2'b00);
        hot_clr = 1'b0;
        edges_then_sample(6);
        chk("R9 cleared state held", {1'b0, hot_warn}, 2'b00);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule